// File: doc/BRIEF.md
# Bottom-Up Merge Sorter

This block takes a batch of signed words and returns them in ascending order. While idle it raises its input ready signal and accepts one word per valid/ready handshake into a primary RAM. Once the last word of the batch is in, it lowers ready and raises busy. It then sorts the batch in place by iterative merging.

The first pass treats every word as a sorted run of length one and merges neighbouring runs into a scratch RAM. The merged pass is then copied back into the primary RAM, and the run length doubles. Passes repeat until a single run covers the whole batch. The sorted words then leave on a valid/ready output stream, lowest first. When the last word has been taken, busy falls and the block accepts the next batch.

Each RAM serves one access per cycle, either a read or a write. The two run heads being compared are therefore held in registers, and only the consumed head is refilled. One shared position counter walks the addresses in every phase: loading, merge writes, copy-back and output.

Top module: `merge_sorter`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, busy and out_valid are 0 and in_ready is 1.
- R2: While not busy, the block accepts exactly 2^LOG_N words, one per cycle in which in_valid and in_ready are both high. in_ready stays 1 and busy stays 0 throughout loading. busy is 1 in the cycle after the last word is accepted.
- R3: While busy is 1, in_ready is 0. Any in_valid and in_data presented then are ignored, so the batch that comes out is exactly the batch that was loaded.
- R4: After sorting, the block delivers exactly 2^LOG_N words on the output stream, one per out_valid/out_ready handshake. They are in non-decreasing order and form the same multiset as the input.
- R5: Ordering uses two's-complement signed comparison of the ELEM_W-bit words. With ELEM_W = 9, the pattern 9'h100 (-256) is the smallest key and 9'h0FF (255) the largest.
- R6: Duplicate keys are all preserved. When keys compare equal, the merge takes the word from the left run first.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change in the next cycle.
- R8: out_valid is 0 in the cycle after the last input is accepted, because output starts only after the final merge pass. In the cycle after the last output handshake, busy and out_valid are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The block is loading and accepts a word |
| in_data | input | ELEM_W | Signed input word |
| out_valid | output | 1 | A sorted word is offered |
| out_ready | input | 1 | The consumer takes the offered word |
| out_data | output | ELEM_W | Signed sorted word |
| busy | output | 1 | A batch is being sorted or unloaded |

## Verification
The bench feeds batches that expose specific faults:
- **Already sorted and reversed batches.** A merge that mishandles a run running out, or reads past the end of a run, duplicates or drops words.
- **Batches mixing -256, 255, 0 and -1.** An unsigned comparison puts the negative values last.
- **A batch with only four distinct values.** A faulty tie rule or head refill loses copies of the repeated keys.

Throughout sorting, in_valid is held high with random data, so a block that does not refuse input while busy corrupts its batch. Random output backpressure exposes a word that changes or vanishes before it is taken.

// File: rtl/msort_pkg.sv
// Package: shared phase encoding of the merge sorter controller.
// Assumes nothing beyond a single clock domain.
package msort_pkg;

    typedef enum logic [3:0] {
        PH_LOAD,    // accepting input words
        PH_PAIR,    // start a merge of two neighbouring runs
        PH_HEADA,   // capture left head, fetch right head
        PH_HEADB,   // capture right head
        PH_PICK,    // compare heads, write the winner to scratch
        PH_FILLA,   // capture refilled left head
        PH_FILLB,   // capture refilled right head
        PH_CPRD,    // copy-back: read scratch
        PH_CPWR,    // copy-back: write primary
        PH_ORD,     // output: read primary
        PH_OHOLD    // output: offer word until taken
    } phase_t;

endpackage

// File: rtl/msort_ram.sv
// Module: single-port RAM with one access per cycle and a registered read.
// Assumes the caller never sets we and re in the same cycle. rdata keeps
// its value until the next read.
module msort_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write or read at the single port.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/msort_cursor.sv
// Module: the shared position counter used by every phase.
// It has one spare top bit that is set for one count when a full sweep of
// 2^(AW-1) positions ends. Clear has priority over increment.
module msort_cursor #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] q
);
    // Count, clear or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q[AW-1] |-> (q[AW-2:0] == '0));

endmodule

// File: rtl/msort_ctrl.sv
// Module: phase sequencer of the merge sorter.
// It loads the batch, runs the bottom-up merge passes with a copy-back
// after each pass, and unloads the result. It assumes both RAMs have a
// one-cycle registered read, and that the cursor counts only when told to.
module msort_ctrl
    import msort_pkg::*;
#(
    parameter int ELEM_W = 9,
    parameter int LOG_N  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [ELEM_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     busy,
    input  logic [LOG_N:0]           cur,
    output logic                     cur_clr,
    output logic                     cur_inc,
    output logic                     prim_we,
    output logic                     prim_re,
    output logic [LOG_N-1:0]         prim_addr,
    output logic [ELEM_W-1:0]        prim_wdata,
    input  logic [ELEM_W-1:0]        prim_rdata,
    output logic                     tmp_we,
    output logic                     tmp_re,
    output logic [LOG_N-1:0]         tmp_addr,
    output logic [ELEM_W-1:0]        tmp_wdata,
    input  logic [ELEM_W-1:0]        tmp_rdata
);
    localparam int IW = LOG_N + 1;
    localparam int N  = 1 << LOG_N;
    localparam logic [IW-1:0] LAST_POS = IW'(N - 1);
    localparam logic [IW-1:0] FULL_RUN = IW'(N);

    phase_t                   phase;
    logic [IW-1:0]            run_len;
    logic [IW-1:0]            l_pos, l_end, r_pos, r_end;
    logic signed [ELEM_W-1:0] l_head, r_head;
    logic                     l_live, r_live;

    logic          take_l, l_more, r_more, cur_last;
    logic [IW-1:0] l_nxt, r_nxt, len_dbl;

    // Head comparison and run bookkeeping, shared by decode and update.
    always_comb begin
        take_l   = l_live && (!r_live || (l_head <= r_head));
        l_nxt    = l_pos + 1'b1;
        r_nxt    = r_pos + 1'b1;
        l_more   = l_nxt < l_end;
        r_more   = r_nxt < r_end;
        cur_last = (cur == LAST_POS);
        len_dbl  = {run_len[IW-2:0], 1'b0};
    end

    // Per-phase RAM, cursor and handshake controls.
    always_comb begin
        prim_we    = 1'b0;
        prim_re    = 1'b0;
        prim_addr  = cur[LOG_N-1:0];
        prim_wdata = in_data;
        tmp_we     = 1'b0;
        tmp_re     = 1'b0;
        tmp_addr   = cur[LOG_N-1:0];
        tmp_wdata  = take_l ? l_head : r_head;
        cur_clr    = 1'b0;
        cur_inc    = 1'b0;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        unique case (phase)
            PH_LOAD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    prim_we = 1'b1;
                    cur_clr = cur_last;
                    cur_inc = !cur_last;
                end
            end
            PH_PAIR: prim_re = 1'b1;
            PH_HEADA: begin
                prim_re   = 1'b1;
                prim_addr = r_pos[LOG_N-1:0];
            end
            PH_PICK: begin
                if (!l_live && !r_live) begin
                    cur_clr = cur[LOG_N];
                end else begin
                    tmp_we  = 1'b1;
                    cur_inc = 1'b1;
                    if (take_l && l_more) begin
                        prim_re   = 1'b1;
                        prim_addr = l_nxt[LOG_N-1:0];
                    end else if (!take_l && r_more) begin
                        prim_re   = 1'b1;
                        prim_addr = r_nxt[LOG_N-1:0];
                    end
                end
            end
            PH_CPRD: tmp_re = 1'b1;
            PH_CPWR: begin
                prim_we    = 1'b1;
                prim_wdata = tmp_rdata;
                cur_clr    = cur_last;
                cur_inc    = !cur_last;
            end
            PH_ORD: prim_re = 1'b1;
            PH_OHOLD: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    cur_clr = cur_last;
                    cur_inc = !cur_last;
                end
            end
            default: ;
        endcase
    end

    assign busy = (phase != PH_LOAD);

    // Phase sequencing and run head registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LOAD;
            run_len <= IW'(1);
            l_pos   <= '0;
            l_end   <= '0;
            r_pos   <= '0;
            r_end   <= '0;
            l_head  <= '0;
            r_head  <= '0;
            l_live  <= 1'b0;
            r_live  <= 1'b0;
        end else begin
            unique case (phase)
                PH_LOAD: begin
                    if (in_valid && cur_last) begin
                        phase   <= PH_PAIR;
                        run_len <= IW'(1);
                    end
                end
                PH_PAIR: begin
                    l_pos <= cur;
                    l_end <= cur + run_len;
                    r_pos <= cur + run_len;
                    r_end <= cur + len_dbl;
                    phase <= PH_HEADA;
                end
                PH_HEADA: begin
                    l_head <= prim_rdata;
                    l_live <= 1'b1;
                    phase  <= PH_HEADB;
                end
                PH_HEADB: begin
                    r_head <= prim_rdata;
                    r_live <= 1'b1;
                    phase  <= PH_PICK;
                end
                PH_PICK: begin
                    if (!l_live && !r_live) begin
                        phase <= cur[LOG_N] ? PH_CPRD : PH_PAIR;
                    end else if (take_l) begin
                        if (l_more) begin
                            l_pos <= l_nxt;
                            phase <= PH_FILLA;
                        end else begin
                            l_live <= 1'b0;
                        end
                    end else begin
                        if (r_more) begin
                            r_pos <= r_nxt;
                            phase <= PH_FILLB;
                        end else begin
                            r_live <= 1'b0;
                        end
                    end
                end
                PH_FILLA: begin
                    l_head <= prim_rdata;
                    phase  <= PH_PICK;
                end
                PH_FILLB: begin
                    r_head <= prim_rdata;
                    phase  <= PH_PICK;
                end
                PH_CPRD: phase <= PH_CPWR;
                PH_CPWR: begin
                    if (cur_last) begin
                        run_len <= len_dbl;
                        phase   <= (len_dbl == FULL_RUN) ? PH_ORD : PH_PAIR;
                    end else begin
                        phase <= PH_CPRD;
                    end
                end
                PH_ORD: phase <= PH_OHOLD;
                PH_OHOLD: begin
                    if (out_ready) begin
                        phase <= cur_last ? PH_LOAD : PH_ORD;
                    end
                end
                default: phase <= PH_LOAD;
            endcase
        end
    end

    // R2
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_ready));

    // R4
    head_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PICK) |-> ((l_pos < l_end) && (r_pos < r_end)));

endmodule

// File: rtl/merge_sorter.sv
// Module: top of the bottom-up merge sorter.
// It connects the primary and scratch RAMs, the shared cursor and the
// sequencer. out_data comes straight from the primary RAM read register,
// which holds its value while a word is being offered.
module merge_sorter #(
    parameter int ELEM_W = 9,
    parameter int LOG_N  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [ELEM_W-1:0] in_data,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic signed [ELEM_W-1:0] out_data,
    output logic                     busy
);
    localparam int IW = LOG_N + 1;

    logic [IW-1:0]     cur;
    logic              cur_clr, cur_inc;
    logic              p_we, p_re, t_we, t_re;
    logic [LOG_N-1:0]  p_addr, t_addr;
    logic [ELEM_W-1:0] p_wdata, p_rdata, t_wdata, t_rdata;

    msort_cursor #(.AW(IW)) u_cursor (
        .clk(clk), .rst_n(rst_n), .clr(cur_clr), .inc(cur_inc), .q(cur)
    );

    msort_ctrl #(.ELEM_W(ELEM_W), .LOG_N(LOG_N)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .busy(busy),
        .cur(cur), .cur_clr(cur_clr), .cur_inc(cur_inc),
        .prim_we(p_we), .prim_re(p_re), .prim_addr(p_addr),
        .prim_wdata(p_wdata), .prim_rdata(p_rdata),
        .tmp_we(t_we), .tmp_re(t_re), .tmp_addr(t_addr),
        .tmp_wdata(t_wdata), .tmp_rdata(t_rdata)
    );

    msort_ram #(.ADDR_W(LOG_N), .DATA_W(ELEM_W)) u_prim (
        .clk(clk), .we(p_we), .re(p_re), .addr(p_addr),
        .wdata(p_wdata), .rdata(p_rdata)
    );

    msort_ram #(.ADDR_W(LOG_N), .DATA_W(ELEM_W)) u_tmp (
        .clk(clk), .we(t_we), .re(t_re), .addr(t_addr),
        .wdata(t_wdata), .rdata(t_rdata)
    );

    assign out_data = p_rdata;

    // Checker state: last word delivered in the current batch.
    logic signed [ELEM_W-1:0] prev_out;
    logic                     have_prev;

    // Track the previous output word for the ordering check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            prev_out  <= '0;
        end else if (out_valid && out_ready) begin
            have_prev <= 1'b1;
            prev_out  <= out_data;
        end else if (!busy) begin
            have_prev <= 1'b0;
        end
    end

    // R4
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && have_prev) |-> (out_data >= prev_out));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/merge_sorter_test.sv
module merge_sorter_test;
    localparam int W  = 9;
    localparam int LN = 8;
    localparam int N  = 1 << LN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [W-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic signed [W-1:0] out_data;
    logic busy;

    always #5 clk = ~clk;

    merge_sorter #(.ELEM_W(W), .LOG_N(LN)) uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int src   [N];
    int sorted_ref [N];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R4 watchdog actual=%0d expected=finished", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Reference: insertion sort of the source batch, signed.
    task automatic make_ref();
        for (int k = 0; k < N; k++) sorted_ref[k] = src[k];
        for (int k = 1; k < N; k++) begin
            int v = sorted_ref[k];
            int m = k - 1;
            while (m >= 0 && sorted_ref[m] > v) begin
                sorted_ref[m+1] = sorted_ref[m];
                m--;
            end
            sorted_ref[m+1] = v;
        end
    endtask

    // Load src, let it sort while offering junk input, then unload with backpressure.
    task automatic run_batch(input string req);
        int idx;
        bit held;
        logic signed [W-1:0] held_val;
        bit rdy;
        int got;
        make_ref();
        for (int k = 0; k < N; k++) begin
            repeat ($urandom % 3) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            if (k == 0 || k == N - 1)
                chk(in_ready && !busy, "R2 ready during load", int'({in_ready, busy}), 2);
            in_valid = 1'b1;
            in_data  = W'(src[k]);
            @(negedge clk);
        end
        chk(busy && !in_ready, "R2 busy after last word", int'({busy, in_ready}), 2);
        chk(!out_valid, "R8 no early output", int'(out_valid), 0);
        in_valid = 1'b1;
        in_data  = W'($urandom);
        idx  = 0;
        held = 1'b0;
        held_val = '0;
        while (idx < N) begin
            if (out_valid) begin
                if (held) chk(out_data == held_val, "R7 data held", int'(out_data), int'(held_val));
                rdy = (($urandom % 4) != 0);
                if (rdy) begin
                    got = out_data;
                    chk(got == sorted_ref[idx], req, got, sorted_ref[idx]);
                    idx++;
                    held = 1'b0;
                    if (idx == N) in_valid = 1'b0;
                end else begin
                    held = 1'b1;
                    held_val = out_data;
                end
                out_ready = rdy;
            end else begin
                if (held) begin
                    chk(1'b0, "R7 valid dropped", 0, 1);
                    held = 1'b0;
                end
                if (busy) chk(!in_ready, "R3 refused while busy", int'(in_ready), 0);
                out_ready = ($urandom % 2) != 0;
                in_data = W'($urandom);
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(!busy && in_ready && !out_valid, "R8 idle after unload",
            int'({busy, in_ready, out_valid}), 2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && in_ready && !out_valid, "R1 reset held", int'({busy, in_ready, out_valid}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && in_ready && !out_valid, "R1 after reset", int'({busy, in_ready, out_valid}), 2);

        // R4 and R3: random full-range batch
        for (int k = 0; k < N; k++) src[k] = int'($urandom % 512) - 256;
        run_batch("R4 random");
        // R4: already ascending
        for (int k = 0; k < N; k++) src[k] = k - 128;
        run_batch("R4 ascending");
        // R4: descending
        for (int k = 0; k < N; k++) src[k] = 127 - k;
        run_batch("R4 descending");
        // R5: signed extremes
        for (int k = 0; k < N; k++) begin
            case (k % 4)
                0: src[k] = 255;
                1: src[k] = -256;
                2: src[k] = 0;
                default: src[k] = -1;
            endcase
        end
        run_batch("R5 signed order");
        // R6: heavy duplicates
        for (int k = 0; k < N; k++) src[k] = int'($urandom % 4) - 2;
        run_batch("R6 duplicates");
        // R3: second random batch right after, confirms junk was ignored
        for (int k = 0; k < N; k++) src[k] = int'($urandom % 512) - 256;
        run_batch("R3 random after junk");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule